// File: doc/BRIEF.md
# SAR converter control sequencer

This block is a clock-cycle model of the digital control and output side of a 16-bit successive-approximation converter. A falling edge on the active-low start input begins a conversion, but only when chip select is low at that edge. The block then holds the value on `sample` and raises `busy` for a fixed number of clock cycles. When `busy` drops, the held value moves into the output latch. A parallel read port shows that latch in one of two views: the whole word, or a fold view for byte-wide hosts. The analog side is not modelled. The value that would come from the capacitor array arrives on a plain input port.

The host can cancel a running conversion. It does so with a second start edge while chip select is low, or with a chip-select falling edge. Either event cancels only if it lands inside a configurable window of elapsed conversion cycles. A cancel, or the asynchronous active-low reset, clears the output latch to zero and starts a recovery period. After that comes a minimum acquisition period. The block accepts no new start until both have passed. After a normal conversion, acquisition time is counted from the later of two events: the end of `busy`, or chip select being low.

Top module: `sarc_ctrl`

## Requirements
- R1: While `rst_n` is low, with or without a clock edge, `busy` is 0 and the output latch reads 0x0000. Reset cancels any conversion in progress.
- R2: A conversion starts only at a clock edge where `start_n` is sampled low after being sampled high at the previous edge, and where `sel_n` is sampled low. `busy` is 1 after that edge. A start edge with `sel_n` high leaves `busy` at 0 and the latch unchanged.
- R3: With no cancel, `busy` stays 1 for exactly CONV_CYC clock cycles. At the edge where it falls, the output latch takes the `sample` value captured at the start edge, bit for bit.
- R4: `bus_drive` is 1 exactly when `sel_n` and `read_n` are both 0. In the other three combinations it is 0.
- R5: With `fold_sel` = 0, `bus_data` is the full latch word. With `fold_sel` = 1, bits 15..8 carry latch bits 7..0 and bits 7..0 read 0xFF.
- R6: Reads made while `busy` is 1 return the previous result until the new one is latched.
- R7: Number the edges after the start edge 1, 2, 3, and so on. A cancel happens when, at edge j of the conversion with ABORT_MIN <= j <= ABORT_MAX, there is either a start falling edge with `sel_n` low or a `sel_n` falling edge. After that edge `busy` is 0 and the latch reads 0x0000.
- R8: The same start or chip-select edges at any other elapsed count during a conversion are ignored. The conversion runs its full length and latches its sample.
- R9: After reset is released, or after a cancel, the earliest start that is accepted falls on edge RECOV_CYC + ACQ_CYC. The count starts with the first edge that has reset high, or with the edge after the cancel edge.
- R10: If `sel_n` is high when a conversion ends, acquisition begins only at the first edge where `sel_n` is sampled low, counted as edge 1. The earliest accepted start is then edge ACQ_CYC + 1.
- R11: The latch carries the two's-complement code unchanged: 0x7FFF, 0x0000, 0xFFFF and 0x8000 all read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset; cancels a conversion and clears the latch |
| start_n | input | 1 | Conversion start, acts on its falling edge |
| sel_n | input | 1 | Active-low chip select |
| read_n | input | 1 | Active-low read strobe |
| fold_sel | input | 1 | 1 selects the byte-fold view of the result |
| sample | input | DW | Converted value presented by the analog model |
| busy | output | 1 | High while a conversion is running |
| bus_data | output | DW | Result view for the data pins |
| bus_drive | output | 1 | Pad drive enable; pins float when 0 |

## Verification
The sequencer state shows up on `busy` on the very next edge. A phase or counter fault makes `busy` rise without a valid start, or fall at a cycle count other than CONV_CYC or a count inside the cancel window. A latch fault shows up on the read port only. So the bench reads the latch after every conversion and every cancel, and again partway through a conversion. A wrong acquisition or recovery count is only visible as a start accepted one edge early or one edge late. For that reason the bench probes both sides of every such boundary.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        PH_RECOV  = 2'd0,
        PH_WAIT   = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    typedef struct packed {
        logic start_fall;
        logic sel_fall;
    } edge_t;

    function automatic logic in_window(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/sarc_edges.sv
module sarc_edges
    import sarc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_n,
    input  logic  sel_n,
    output edge_t ev
);
    logic start_q;
    logic sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b1;
            sel_q   <= 1'b1;
        end else begin
            start_q <= start_n;
            sel_q   <= sel_n;
        end
    end

    always_comb begin
        ev.start_fall = start_q & ~start_n;
        ev.sel_fall   = sel_q & ~sel_n;
    end
endmodule

// File: rtl/sarc_seq.sv
module sarc_seq
    import sarc_pkg::*;
#(
    parameter int CONV_CYC  = 16,
    parameter int ABORT_MIN = 4,
    parameter int ABORT_MAX = 12,
    parameter int RECOV_CYC = 3,
    parameter int ACQ_CYC   = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_n,
    input  edge_t  ev,
    output phase_e phase,
    output logic   take,
    output logic   finish,
    output logic   kill
);
    localparam int CW = $clog2(CONV_CYC + 1);
    localparam int RW = $clog2(RECOV_CYC + 1);
    localparam int AW = $clog2(ACQ_CYC + 1);

    logic [CW-1:0] conv_cnt;
    logic [RW-1:0] rec_cnt;
    logic [AW-1:0] acq_cnt;
    logic [CW:0]   elapsed;
    logic          hit;
    logic          acq_ok;

    always_comb begin
        elapsed = {1'b0, conv_cnt} + (CW+1)'(1);
        hit     = (ev.start_fall & ~sel_n) | ev.sel_fall;
        kill    = (phase == PH_CONV) && hit &&
                  in_window(int'(elapsed), ABORT_MIN, ABORT_MAX);
        acq_ok  = (acq_cnt >= AW'(ACQ_CYC - 1));
        take    = (phase == PH_SAMPLE) && ev.start_fall && !sel_n && acq_ok;
        finish  = (phase == PH_CONV) && !kill && (conv_cnt == CW'(CONV_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_RECOV;
            conv_cnt <= '0;
            rec_cnt  <= '0;
            acq_cnt  <= '0;
        end else begin
            case (phase)
                PH_RECOV: begin
                    if (rec_cnt == RW'(RECOV_CYC - 1)) begin
                        phase   <= PH_SAMPLE;
                        acq_cnt <= '0;
                    end else begin
                        rec_cnt <= rec_cnt + RW'(1);
                    end
                end
                PH_WAIT: begin
                    if (!sel_n) begin
                        phase   <= PH_SAMPLE;
                        acq_cnt <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (take) begin
                        phase    <= PH_CONV;
                        conv_cnt <= '0;
                    end else if (!acq_ok) begin
                        acq_cnt <= acq_cnt + AW'(1);
                    end
                end
                PH_CONV: begin
                    if (kill) begin
                        phase   <= PH_RECOV;
                        rec_cnt <= '0;
                    end else if (finish) begin
                        phase   <= sel_n ? PH_WAIT : PH_SAMPLE;
                        acq_cnt <= '0;
                    end else begin
                        conv_cnt <= conv_cnt + CW'(1);
                    end
                end
                default: phase <= PH_RECOV;
            endcase
        end
    end
endmodule

// File: rtl/sarc_out.sv
module sarc_out #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sample,
    input  logic          take,
    input  logic          finish,
    input  logic          kill,
    input  logic          sel_n,
    input  logic          read_n,
    input  logic          fold_sel,
    output logic [DW-1:0] bus_data,
    output logic          bus_drive
);
    localparam int HW = DW / 2;

    logic [DW-1:0] hold_q;
    logic [DW-1:0] result_q;
    logic [DW-1:0] fold_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            result_q <= '0;
        end else begin
            if (take) hold_q <= sample;
            if (kill) result_q <= '0;
            else if (finish) result_q <= hold_q;
        end
    end

    generate
        if (DW - HW == HW) begin : g_even
            assign fold_view = {result_q[HW-1:0], {HW{1'b1}}};
        end else begin : g_odd
            assign fold_view = {result_q[DW-HW-1:0], {HW{1'b1}}};
        end
    endgenerate

    always_comb begin
        bus_drive = !sel_n && !read_n;
        bus_data  = fold_sel ? fold_view : result_q;
    end
endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
    import sarc_pkg::*;
#(
    parameter int DW        = WORD_W,
    parameter int CONV_CYC  = 16,
    parameter int ABORT_MIN = 4,
    parameter int ABORT_MAX = 12,
    parameter int RECOV_CYC = 3,
    parameter int ACQ_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n,
    input  logic          sel_n,
    input  logic          read_n,
    input  logic          fold_sel,
    input  logic [DW-1:0] sample,
    output logic          busy,
    output logic [DW-1:0] bus_data,
    output logic          bus_drive
);
    edge_t  ev;
    phase_e phase;
    logic   take;
    logic   finish;
    logic   kill;

    sarc_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_n (start_n),
        .sel_n   (sel_n),
        .ev      (ev)
    );

    sarc_seq #(
        .CONV_CYC  (CONV_CYC),
        .ABORT_MIN (ABORT_MIN),
        .ABORT_MAX (ABORT_MAX),
        .RECOV_CYC (RECOV_CYC),
        .ACQ_CYC   (ACQ_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .ev     (ev),
        .phase  (phase),
        .take   (take),
        .finish (finish),
        .kill   (kill)
    );

    sarc_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .take      (take),
        .finish    (finish),
        .kill      (kill),
        .sel_n     (sel_n),
        .read_n    (read_n),
        .fold_sel  (fold_sel),
        .bus_data  (bus_data),
        .bus_drive (bus_drive)
    );

    assign busy = (phase == PH_CONV);
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk #(
    parameter int DW        = 16,
    parameter int CONV_CYC  = 16,
    parameter int ABORT_MIN = 4,
    parameter int ABORT_MAX = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_n,
    input logic          sel_n,
    input logic          read_n,
    input logic          fold_sel,
    input logic          busy,
    input logic [DW-1:0] bus_data,
    input logic          bus_drive
);
    localparam int HW = DW / 2;
    localparam int BW = $clog2(CONV_CYC + 2) + 1;

    logic [BW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= run_len + BW'(1);
        else run_len <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (busy == 1'b0); // R1
        end
    end

    AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!sel_n && !start_n)); // R2

    AST_BUSY_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= BW'(CONV_CYC)); // R3

    AST_BUSY_END_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((run_len == BW'(CONV_CYC)) ||
                         ((run_len >= BW'(ABORT_MIN)) && (run_len <= BW'(ABORT_MAX))))); // R7

    AST_OLD_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !sel_n && !read_n && $past(!sel_n && !read_n) &&
         $stable(fold_sel)) |-> $stable(bus_data)); // R6

    AST_FOLD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && fold_sel && $past(!fold_sel) && bus_drive && $past(bus_drive))
        |-> (bus_data[DW-1:DW-HW] == $past(bus_data[HW-1:0]))); // R5
endmodule

bind sarc_ctrl sarc_chk #(
    .DW        (DW),
    .CONV_CYC  (CONV_CYC),
    .ABORT_MIN (ABORT_MIN),
    .ABORT_MAX (ABORT_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_n   (start_n),
    .sel_n     (sel_n),
    .read_n    (read_n),
    .fold_sel  (fold_sel),
    .busy      (busy),
    .bus_data  (bus_data),
    .bus_drive (bus_drive)
);

// File: tb/tb_sarc_ctrl.sv
`timescale 1ns/1ps
module tb_sarc_ctrl;
    localparam int DW = 16;
    localparam int CONV_CYC = 16;
    localparam int ABORT_MIN = 4;
    localparam int ABORT_MAX = 12;
    localparam int RECOV_CYC = 3;
    localparam int ACQ_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1;
    logic sel_n = 1'b0;
    logic read_n = 1'b1;
    logic fold_sel = 1'b0;
    logic [DW-1:0] sample = '0;
    logic busy;
    logic [DW-1:0] bus_data;
    logic bus_drive;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sarc_ctrl #(
        .DW(DW), .CONV_CYC(CONV_CYC), .ABORT_MIN(ABORT_MIN),
        .ABORT_MAX(ABORT_MAX), .RECOV_CYC(RECOV_CYC), .ACQ_CYC(ACQ_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .sel_n(sel_n),
        .read_n(read_n), .fold_sel(fold_sel), .sample(sample),
        .busy(busy), .bus_data(bus_data), .bus_drive(bus_drive)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic nw(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic fs, input logic [DW-1:0] exp);
        sel_n = 1'b0;
        read_n = 1'b0;
        fold_sel = fs;
        #1;
        chk({tag, " drive"}, 32'(bus_drive), 32'(1));
        chk({tag, " data"}, 32'(bus_data), 32'(exp));
        read_n = 1'b1;
        fold_sel = 1'b0;
    endtask

    task automatic settle();
        start_n = 1'b1;
        sel_n = 1'b0;
        read_n = 1'b1;
        while (busy) @(negedge clk);
        nw(RECOV_CYC + ACQ_CYC + 2);
    endtask

    task automatic do_conv(input logic [DW-1:0] v);
        settle();
        sample = v;
        start_n = 1'b0;
        nw(1);
        chk("R2 busy after start", 32'(busy), 32'(1));
        start_n = 1'b1;
        sample = ~v;
        nw(CONV_CYC - 1);
        chk("R3 busy last cycle", 32'(busy), 32'(1));
        nw(1);
        chk("R3 busy fallen", 32'(busy), 32'(0));
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        nw(1);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 40000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] codes [6];
        codes[0] = 16'h7FFF; codes[1] = 16'h0000; codes[2] = 16'hFFFF;
        codes[3] = 16'h8000; codes[4] = 16'h1234; codes[5] = 16'hA5C3;

        // R1: state while reset held
        nw(2);
        chk("R1 busy in reset", 32'(busy), 32'(0));
        rd_chk("R1 latch in reset", 1'b0, 16'h0000);
        rst_n = 1'b1;
        settle();

        // R4: bus enable over all select/read combinations
        for (int c = 0; c < 4; c++) begin
            sel_n = c[0];
            read_n = c[1];
            #1;
            chk("R4 drive enable", 32'(bus_drive), 32'(c == 0));
        end
        sel_n = 1'b0;
        read_n = 1'b1;

        // R3 R5 R11: codes through full conversions, both views
        foreach (codes[k]) begin
            do_conv(codes[k]);
            rd_chk("R11 full word", 1'b0, codes[k]);
            rd_chk("R5 fold view", 1'b1, {codes[k][7:0], 8'hFF});
        end

        // R2: start with select high is ignored
        settle();
        sel_n = 1'b1;
        sample = 16'h0F0F;
        start_n = 1'b0;
        nw(2);
        chk("R2 start ignored with select high", 32'(busy), 32'(0));
        start_n = 1'b1;
        rd_chk("R2 latch unchanged", 1'b0, codes[5]);

        // R6: previous result during conversion
        do_conv(16'h2468);
        settle();
        sample = 16'h1357;
        start_n = 1'b0;
        nw(1);
        start_n = 1'b1;
        nw(5);
        rd_chk("R6 old result mid conversion", 1'b0, 16'h2468);
        rd_chk("R6 old fold mid conversion", 1'b1, 16'h68FF);
        while (busy) @(negedge clk);
        rd_chk("R6 new result after end", 1'b0, 16'h1357);

        // R7 R8: cancel window sweep, start edge and select edge
        for (int kind = 0; kind < 2; kind++) begin
            for (int j = 2; j < CONV_CYC; j++) begin
                logic win;
                win = (j >= ABORT_MIN) && (j <= ABORT_MAX);
                do_conv(16'h3C00 + 16'(j));
                settle();
                sample = 16'hC000 | 16'(j);
                start_n = 1'b0;
                nw(1);
                start_n = 1'b1;
                if (kind == 1) sel_n = 1'b1;
                nw(j - 1);
                if (kind == 0) start_n = 1'b0;
                else sel_n = 1'b0;
                nw(1);
                if (win) chk("R7 cancel drops busy", 32'(busy), 32'(0));
                else chk("R8 edge ignored busy held", 32'(busy), 32'(1));
                start_n = 1'b1;
                while (busy) @(negedge clk);
                if (win) rd_chk("R7 latch cleared", 1'b0, 16'h0000);
                else rd_chk("R8 conversion completed", 1'b0, 16'hC000 | 16'(j));
            end
        end

        // R9: earliest start after cancel
        do_conv(16'h5555);
        settle();
        start_n = 1'b0;
        nw(1);
        start_n = 1'b1;
        nw(ABORT_MIN - 1);
        start_n = 1'b0;
        nw(1);
        chk("R9 cancel taken", 32'(busy), 32'(0));
        start_n = 1'b1;
        nw(RECOV_CYC + ACQ_CYC - 2);
        start_n = 1'b0;
        nw(1);
        chk("R9 start one edge early after cancel", 32'(busy), 32'(0));
        start_n = 1'b1;
        nw(1);
        start_n = 1'b0;
        nw(1);
        chk("R9 start after recovery accepted", 32'(busy), 32'(1));
        start_n = 1'b1;
        settle();

        // R1: asynchronous reset mid conversion
        do_conv(16'h7777);
        settle();
        sample = 16'h4444;
        start_n = 1'b0;
        nw(1);
        start_n = 1'b1;
        nw(5);
        #2;
        rst_n = 1'b0;
        #1;
        chk("R1 async reset drops busy", 32'(busy), 32'(0));
        rd_chk("R1 async reset clears latch", 1'b0, 16'h0000);
        nw(1);
        rst_n = 1'b1;

        // R9: earliest start after reset release
        pulse_reset();
        nw(RECOV_CYC + ACQ_CYC - 2);
        start_n = 1'b0;
        nw(1);
        chk("R9 start one edge early after reset", 32'(busy), 32'(0));
        nw(2);
        chk("R9 held low start not retaken", 32'(busy), 32'(0));
        start_n = 1'b1;
        pulse_reset();
        nw(RECOV_CYC + ACQ_CYC - 1);
        start_n = 1'b0;
        nw(1);
        chk("R9 first legal start after reset", 32'(busy), 32'(1));
        start_n = 1'b1;
        settle();

        // R10: acquisition counted from select low after end
        for (int run = 0; run < 2; run++) begin
            do_conv(16'h0A0A);
            settle();
            sample = 16'h0B0B;
            start_n = 1'b0;
            nw(1);
            start_n = 1'b1;
            sel_n = 1'b1;
            nw(CONV_CYC + 3);
            sel_n = 1'b0;
            nw(ACQ_CYC - 1 + run);
            start_n = 1'b0;
            nw(1);
            if (run == 0) chk("R10 start before acquisition done", 32'(busy), 32'(0));
            else chk("R10 start after acquisition accepted", 32'(busy), 32'(1));
            start_n = 1'b1;
            settle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule